// File: doc/BRIEF.md
# Multi-Port Register File

A storage array of `N_WORDS` words of `DATA_W` bits with `N_RD` read ports and `N_WR` write ports. The address, enable and data signals of all ports travel on wide packed buses, with port `i` always in slice `i`. Each port is set up on its own through bit-vector parameters. A read port can be combinational or registered, can act on the rising or the falling edge of its own port clock, and, when registered, can return either the contents from before or from after the writes of the same edge. A write port can act on an edge of its port clock or, when it is unclocked, on every core cycle. Every write port carries one enable bit for each data bit.

The block runs on a single core clock `clk` with a synchronous, active-high `rst`. Each port clock input is sampled by `clk`. An active edge on a port clock is recognised in the first core cycle in which the new level is seen, and it takes effect at the end of that core cycle. When several write ports update the same bit in one core cycle, the port with the highest index wins. On reset the array loads the image given in `INIT_IMAGE`, with word `w` in bits `[w*DATA_W +: DATA_W]`.

Top module: `mpmem_regfile`

## Requirements
- R1: While `rst` is high at a `clk` rising edge, every registered read output becomes zero and word `w` of the array becomes `INIT_IMAGE[w*DATA_W +: DATA_W]`.
- R2: A clocked write port changes the array only in the core cycle in which an active edge of its port clock is detected. With no such edge, its address, data and enables have no effect.
- R3: A write port changes only those bits of the addressed word whose enable bit in `wr_en_i[p*DATA_W +: DATA_W]` is 1. Port `p` uses address slice `[p*ADDR_W +: ADDR_W]` and data slice `[p*DATA_W +: DATA_W]`.
- R4: When two or more write ports update the same bit in the same core cycle, the value from the highest-numbered port is stored.
- R5: A read port whose `RD_SYNC_MASK` bit is 0 shows the current word at its address on `rd_data_o[i*DATA_W +: DATA_W]` combinationally, regardless of its port clock and enable.
- R6: A registered read port loads a new value only in a core cycle that has both an active edge on its port clock and a 1 on its `rd_en_i` bit. Otherwise it holds its value.
- R7: A registered read port whose `RD_PASS_MASK` bit is 0 returns the word as it was before the writes of the same core cycle.
- R8: A registered read port whose `RD_PASS_MASK` bit is 1 returns the word after all writes of the same core cycle have been merged.
- R9: An edge-mask bit of 1 selects the rising edge of that port clock and 0 selects the falling edge. A port set to the falling edge does not capture on a rising edge.
- R10: A write port whose `WR_SYNC_MASK` bit is 0 ignores its port clock and writes its enabled bits in every core cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_clk_i | input | N_RD | Per-read-port clock, sampled by `clk` |
| rd_en_i | input | N_RD | Per-read-port capture enable |
| rd_addr_i | input | N_RD*ADDR_W | Packed read addresses |
| rd_data_o | output | N_RD*DATA_W | Packed read data |
| wr_clk_i | input | N_WR | Per-write-port clock, sampled by `clk` |
| wr_en_i | input | N_WR*DATA_W | Packed per-bit write enables |
| wr_addr_i | input | N_WR*ADDR_W | Packed write addresses |
| wr_data_i | input | N_WR*DATA_W | Packed write data |

## Verification
The bench builds the array with 8 words of 8 bits, four read ports and three write ports. Read port 0 is combinational. Ports 1 and 2 are registered on the rising edge, with port 2 set to return post-write data. Port 3 is registered on the falling edge. Write ports 0 and 1 act on the rising edge, and write port 2 is unclocked. With this mix, one shared port clock reaches every read mode, same-address collisions between the two clocked writers, and partial-mask merges. The small address space lets a 200-step arithmetic sweep hit each word many times under changing masks and enables, and a bench shadow array predicts every output.

// File: rtl/mpmem_pkg.sv
package mpmem_pkg;

    // How a read port produces its data
    typedef enum logic [1:0] {
        RD_COMB    = 2'd0,   // combinational from the array
        RD_REG_OLD = 2'd1,   // registered, pre-write contents
        RD_REG_NEW = 2'd2    // registered, post-write contents
    } rd_mode_e;

    function automatic rd_mode_e pick_mode(input logic sync_bit, input logic pass_bit);
        if (!sync_bit) begin
            return RD_COMB;
        end
        return pass_bit ? RD_REG_NEW : RD_REG_OLD;
    endfunction

    // True when an address selects an existing word
    function automatic logic addr_ok(input int unsigned a, input int unsigned n);
        return a < n;
    endfunction

endpackage

// File: rtl/mpmem_edge_detect.sv
module mpmem_edge_detect #(
    parameter int            N   = 2,
    parameter logic [N-1:0]  POL = '1
) (
    input  logic         clk,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] evt_o
);

    logic [N-1:0] prev_q;

    // Follows the pin level every cycle; no reset needed since it
    // converges in one cycle and reset blocks all effects meanwhile.
    always_ff @(posedge clk) begin
        prev_q <= pin_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign evt_o[i] = (pin_i[i] != prev_q[i]) && (pin_i[i] == POL[i]);
    end

endmodule

// File: rtl/mpmem_wr_merge.sv
module mpmem_wr_merge import mpmem_pkg::*; #(
    parameter int N_WORDS = 16,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int N_WR    = 2
) (
    input  logic [N_WORDS-1:0][DATA_W-1:0] mem_q,
    input  logic [N_WR-1:0]                fire_i,
    input  logic [N_WR*ADDR_W-1:0]         addr_i,
    input  logic [N_WR*DATA_W-1:0]         en_i,
    input  logic [N_WR*DATA_W-1:0]         data_i,
    output logic [N_WORDS-1:0][DATA_W-1:0] mem_d
);

    // Ports applied in ascending index order: the last one wins a bit.
    always_comb begin
        logic [ADDR_W-1:0] a;
        mem_d = mem_q;
        for (int p = 0; p < N_WR; p++) begin
            a = addr_i[p*ADDR_W +: ADDR_W];
            if (fire_i[p] && addr_ok(32'(a), N_WORDS)) begin
                for (int b = 0; b < DATA_W; b++) begin
                    if (en_i[p*DATA_W + b]) begin
                        mem_d[a][b] = data_i[p*DATA_W + b];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mpmem_rd_port.sv
module mpmem_rd_port import mpmem_pkg::*; #(
    parameter int       N_WORDS = 16,
    parameter int       ADDR_W  = 4,
    parameter int       DATA_W  = 8,
    parameter rd_mode_e MODE    = RD_COMB
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           evt_i,
    input  logic                           en_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [N_WORDS-1:0][DATA_W-1:0] mem_q,
    input  logic [N_WORDS-1:0][DATA_W-1:0] mem_d,
    output logic [DATA_W-1:0]              data_o
);

    logic hit;
    assign hit = addr_ok(32'(addr_i), N_WORDS);

    if (MODE == RD_COMB) begin : g_comb
        always_comb begin
            data_o = hit ? mem_q[addr_i] : '0;
        end
        logic unused_comb;
        assign unused_comb = ^{clk, rst, evt_i, en_i, mem_d};
    end else begin : g_reg
        logic [DATA_W-1:0] src;
        always_comb begin
            if (!hit) begin
                src = '0;
            end else if (MODE == RD_REG_NEW) begin
                src = mem_d[addr_i];
            end else begin
                src = mem_q[addr_i];
            end
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                data_o <= '0;
            end else if (evt_i && en_i) begin
                data_o <= src;
            end
        end
        logic unused_reg;
        assign unused_reg = ^{mem_q, mem_d};
    end

endmodule

// File: rtl/mpmem_regfile.sv
module mpmem_regfile import mpmem_pkg::*; #(
    parameter int                        N_WORDS      = 16,
    parameter int                        ADDR_W       = 4,
    parameter int                        DATA_W       = 8,
    parameter int                        N_RD         = 2,
    parameter int                        N_WR         = 2,
    parameter logic [N_RD-1:0]           RD_SYNC_MASK = 2'b10,
    parameter logic [N_RD-1:0]           RD_EDGE_MASK = '1,
    parameter logic [N_RD-1:0]           RD_PASS_MASK = '0,
    parameter logic [N_WR-1:0]           WR_SYNC_MASK = '1,
    parameter logic [N_WR-1:0]           WR_EDGE_MASK = '1,
    parameter logic [N_WORDS*DATA_W-1:0] INIT_IMAGE   = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_RD-1:0]          rd_clk_i,
    input  logic [N_RD-1:0]          rd_en_i,
    input  logic [N_RD*ADDR_W-1:0]   rd_addr_i,
    output logic [N_RD*DATA_W-1:0]   rd_data_o,
    input  logic [N_WR-1:0]          wr_clk_i,
    input  logic [N_WR*DATA_W-1:0]   wr_en_i,
    input  logic [N_WR*ADDR_W-1:0]   wr_addr_i,
    input  logic [N_WR*DATA_W-1:0]   wr_data_i
);

    logic [N_WORDS-1:0][DATA_W-1:0] mem_q;
    logic [N_WORDS-1:0][DATA_W-1:0] mem_d;
    logic [N_RD-1:0]                rd_evt;
    logic [N_WR-1:0]                wr_evt;
    logic [N_WR-1:0]                wr_fire;

    mpmem_edge_detect #(.N(N_RD), .POL(RD_EDGE_MASK)) u_rd_edge (
        .clk   (clk),
        .pin_i (rd_clk_i),
        .evt_o (rd_evt)
    );

    mpmem_edge_detect #(.N(N_WR), .POL(WR_EDGE_MASK)) u_wr_edge (
        .clk   (clk),
        .pin_i (wr_clk_i),
        .evt_o (wr_evt)
    );

    // Unclocked write ports fire every core cycle
    assign wr_fire = wr_evt | ~WR_SYNC_MASK;

    mpmem_wr_merge #(
        .N_WORDS (N_WORDS),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .N_WR    (N_WR)
    ) u_merge (
        .mem_q  (mem_q),
        .fire_i (wr_fire),
        .addr_i (wr_addr_i),
        .en_i   (wr_en_i),
        .data_i (wr_data_i),
        .mem_d  (mem_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= INIT_IMAGE;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        localparam rd_mode_e MODE_G = pick_mode(RD_SYNC_MASK[g], RD_PASS_MASK[g]);
        mpmem_rd_port #(
            .N_WORDS (N_WORDS),
            .ADDR_W  (ADDR_W),
            .DATA_W  (DATA_W),
            .MODE    (MODE_G)
        ) u_port (
            .clk    (clk),
            .rst    (rst),
            .evt_i  (rd_evt[g]),
            .en_i   (rd_en_i[g]),
            .addr_i (rd_addr_i[g*ADDR_W +: ADDR_W]),
            .mem_q  (mem_q),
            .mem_d  (mem_d),
            .data_o (rd_data_o[g*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/mpmem_regfile_chk.sv
module mpmem_regfile_chk import mpmem_pkg::*; #(
    parameter int              N_WORDS      = 16,
    parameter int              ADDR_W       = 4,
    parameter int              DATA_W       = 8,
    parameter int              N_RD         = 2,
    parameter int              N_WR         = 2,
    parameter logic [N_RD-1:0] RD_SYNC_MASK = 2'b10
) (
    input logic                      clk,
    input logic                      rst,
    input logic [N_RD*DATA_W-1:0]    rd_data_o,
    input logic [N_RD-1:0]           rd_evt,
    input logic [N_RD-1:0]           rd_en_i,
    input logic [N_WORDS*DATA_W-1:0] mem_q,
    input logic [N_WR-1:0]           wr_fire,
    input logic [N_WR*ADDR_W-1:0]    wr_addr_i,
    input logic [N_WR*DATA_W-1:0]    wr_en_i
);

    // Bits that some firing write port is allowed to touch this cycle
    logic [N_WORDS*DATA_W-1:0] cov;
    always_comb begin
        int unsigned a;
        cov = '0;
        for (int p = 0; p < N_WR; p++) begin
            a = 32'(wr_addr_i[p*ADDR_W +: ADDR_W]);
            if (wr_fire[p] && addr_ok(a, N_WORDS)) begin
                for (int b = 0; b < DATA_W; b++) begin
                    if (wr_en_i[p*DATA_W + b]) begin
                        cov[a*DATA_W + b] = 1'b1;
                    end
                end
            end
        end
    end

    assert_no_write_no_change_R2: assert property (@(posedge clk) disable iff (rst)
        !(|cov) |=> $stable(mem_q));

    assert_masked_bits_only_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((mem_q ^ $past(mem_q)) & ~$past(cov)) == '0);

    for (genvar i = 0; i < N_RD; i++) begin : g_port
        if (RD_SYNC_MASK[i]) begin : g_sync
            assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> rd_data_o[i*DATA_W +: DATA_W] == '0);

            assert_sync_hold_R6: assert property (@(posedge clk) disable iff (rst)
                !(rd_evt[i] && rd_en_i[i]) |=> $stable(rd_data_o[i*DATA_W +: DATA_W]));
        end
    end

endmodule

bind mpmem_regfile mpmem_regfile_chk #(
    .N_WORDS      (N_WORDS),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .N_RD         (N_RD),
    .N_WR         (N_WR),
    .RD_SYNC_MASK (RD_SYNC_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_data_o (rd_data_o),
    .rd_evt    (rd_evt),
    .rd_en_i   (rd_en_i),
    .mem_q     (mem_q),
    .wr_fire   (wr_fire),
    .wr_addr_i (wr_addr_i),
    .wr_en_i   (wr_en_i)
);

// File: tb/mpmem_regfile_tb.sv
module mpmem_regfile_tb_top;

    function automatic logic [7:0] init_word(input int i);
        return 8'((i * 43 + 17) & 255);
    endfunction

    function automatic logic [63:0] make_init();
        logic [63:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i*8 +: 8] = init_word(i);
        end
        return r;
    endfunction

    localparam logic [63:0] TB_INIT = make_init();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pclk = 1'b0;
    logic [3:0]  rd_en = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [23:0] wr_en = '0;
    logic [8:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [3:0]  rd_clk_w;
    logic [2:0]  wr_clk_w;

    assign rd_clk_w = {4{pclk}};
    assign wr_clk_w = {3{pclk}};

    // 10 ns period: 100 MHz
    always #(5ns) clk = ~clk;

    mpmem_regfile #(
        .N_WORDS      (8),
        .ADDR_W       (3),
        .DATA_W       (8),
        .N_RD         (4),
        .N_WR         (3),
        .RD_SYNC_MASK (4'b1110),
        .RD_EDGE_MASK (4'b0111),
        .RD_PASS_MASK (4'b0100),
        .WR_SYNC_MASK (3'b011),
        .WR_EDGE_MASK (3'b111),
        .INIT_IMAGE   (TB_INIT)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .rd_clk_i  (rd_clk_w),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wr_clk_i  (wr_clk_w),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data)
    );

    int nvec = 0;
    int nbad = 0;
    logic [7:0] shadow [8];
    logic [7:0] hold [4];

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply_write(input int a, input logic [7:0] m, input logic [7:0] d);
        shadow[a] = (shadow[a] & ~m) | (d & m);
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nvec++;
        nbad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: registered outputs cleared by reset
        check("R1 port1 reset", rd_data[15:8], 8'h00);
        check("R1 port2 reset", rd_data[23:16], 8'h00);
        check("R1 port3 reset", rd_data[31:24], 8'h00);
        // R1, R5: init image visible through the combinational port, no clock edges
        for (int a = 0; a < 8; a++) begin
            shadow[a] = init_word(a);
            rd_addr[2:0] = 3'(a);
            #1;
            check("R1 R5 init image", rd_data[7:0], init_word(a));
        end
        for (int i = 0; i < 4; i++) hold[i] = 8'h00;
        @(negedge clk);

        // Sweep: collisions, masks, enables, both read flavours, both edges
        for (int n = 0; n < 200; n++) begin
            int wa0, wa1, ra0, ra1, ra2, ra3;
            logic [7:0] m0, m1, d0, d1;
            logic [3:0] ev;
            wa0 = n % 8;
            wa1 = (n * 5) % 8;
            ra0 = (n + 2) % 8;
            ra1 = (n % 2 == 1) ? wa0 : (n + 5) % 8;
            ra2 = (n % 3 == 0) ? wa0 : wa1;
            ra3 = (n * 7) % 8;
            m0 = 8'((n * 37 + 1) & 255);
            m1 = (n % 5 == 4) ? 8'h00 : 8'((n * 91 + 15) & 255);
            d0 = 8'((n * 13 + 5) & 255);
            d1 = 8'((n * 29 + 160) & 255);
            ev = 4'b1111;
            if (n % 7 == 3) begin
                ev[1] = 1'b0;
                ev[2] = 1'b0;
            end
            if (n % 4 == 1) ev[3] = 1'b0;

            wr_addr = {3'd0, 3'(wa1), 3'(wa0)};
            wr_en   = {8'h00, m1, m0};
            wr_data = {8'h00, d1, d0};
            rd_addr = {3'(ra3), 3'(ra2), 3'(ra1), 3'(ra0)};
            rd_en   = ev;
            pclk    = 1'b1;

            if (ev[1]) hold[1] = shadow[ra1];       // pre-write word
            apply_write(wa0, m0, d0);
            apply_write(wa1, m1, d1);               // higher index last
            if (ev[2]) hold[2] = shadow[ra2];       // post-write word

            next_cycle();
            check("R3 R4 R5 async after write", rd_data[7:0], shadow[ra0]);
            check(ev[1] ? "R7 old data" : "R6 hold port1", rd_data[15:8], hold[1]);
            check(ev[2] ? "R8 new data" : "R6 hold port2", rd_data[23:16], hold[2]);
            check("R9 falling port ignores rise", rd_data[31:24], hold[3]);

            pclk = 1'b0;
            if (ev[3]) hold[3] = shadow[ra3];
            next_cycle();
            check(ev[3] ? "R9 falling capture" : "R6 hold port3", rd_data[31:24], hold[3]);
        end

        // R4: full-mask collision, port 1 must win
        wr_addr = {3'd0, 3'd6, 3'd6};
        wr_en   = {8'h00, 8'hFF, 8'hFF};
        wr_data = {8'h00, 8'h22, 8'h11};
        rd_addr = 12'd6;
        rd_en   = 4'b0000;
        pclk    = 1'b1;
        shadow[6] = 8'h22;
        next_cycle();
        check("R4 priority collision", rd_data[7:0], 8'h22);
        pclk = 1'b0;
        next_cycle();

        // R2: clocked ports see no edge; inputs churn, array must not move
        for (int k = 0; k < 4; k++) begin
            wr_addr = {3'd0, 3'(k), 3'(7 - k)};
            wr_en   = {8'h00, 8'hFF, 8'hFF};
            wr_data = {8'h00, 8'(k * 17), 8'(k * 51 + 3)};
            next_cycle();
        end
        wr_en = '0;
        for (int a = 0; a < 8; a++) begin
            rd_addr[2:0] = 3'(a);
            #1;
            check("R2 no edge no write", rd_data[7:0], shadow[a]);
        end

        // R10: unclocked port 2 writes with the port clock held still
        @(negedge clk);
        wr_addr = {3'd2, 6'd0};
        wr_en   = {8'hF0, 16'h0000};
        wr_data = {8'hA5, 16'h0000};
        apply_write(2, 8'hF0, 8'hA5);
        next_cycle();
        wr_en = '0;
        rd_addr[2:0] = 3'd2;
        #1;
        check("R10 unclocked partial write", rd_data[7:0], shadow[2]);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule